// File: doc/BRIEF.md
# Word-Interleaved Four-Bank Memory

This block is a memory built from four independent banks that share one request port. Each word address picks a bank from its two lowest bits, so a run of consecutive addresses walks through the banks in turn. Each access in the run can then start while the previous ones are still in progress. After a bank is accessed it stays busy for a fixed number of clocks, its cycle time, before it will take another access.

A request is taken when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` drops while the bank the current request targets is still inside its cycle time. The request then waits at the port: it is never reordered and never overtaken. Reads return their data a fixed number of clocks after they are taken, with a one-cycle valid strobe. A small queue of bank indices holds the order in which reads were issued, and responses leave in that order.

Sequential streams reach one access per clock when the bank count is at least the cycle time. Repeated accesses to one bank run at the speed of a single bank.

Top module: `ilv_mem`

## Requirements
- R1: The bank index of a request is `req_addr[1:0]` and the word within the bank is `req_addr[ADDR_W-1:2]`. A read of an address returns the last data written to that same address.
- R2: After reset `rsp_valid` is low and `req_ready` is high for every address, because all banks are free.
- R3: After a bank takes an access, `req_ready` is low for requests to that bank during the next `CYCLE_T-1` cycles. It is high again in the `CYCLE_T`-th cycle after the access was taken.
- R4: A busy bank holds back only requests that target it. Requests to free banks are taken in consecutive cycles, so a run of sequential addresses is taken one per cycle when `CYCLE_T` is at most 4.
- R5: Read data appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, `LAT` cycles after the cycle in which the read was taken.
- R6: Read responses leave in the order in which the reads were taken, whatever banks they used.
- R7: A write produces no response on `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write data |
| req_ready | output | 1 | The target bank is free, so the request is taken on this edge |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | WORD_W | Read data |

## Verification
A busy counter that is wrong in one bank shows at the port straight away. `req_ready` then changes in the wrong cycle for requests to that bank, so the stall count of a same-bank pair differs from `CYCLE_T-1`. An order queue that has gone out of step shows a response whose data belongs to a different read. A latency counter that is wrong moves the valid strobe away from the cycle that is `LAT` cycles after the read was taken. Each of these faults is visible at the first response or stall that depends on the faulty state.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Kind of access carried by a request.
  typedef enum logic {ACC_READ = 1'b0, ACC_WRITE = 1'b1} acc_kind_e;

  // Value loaded into a bank busy counter when the bank takes an access.
  function automatic int unsigned busy_load(input int unsigned cycle_t);
    return (cycle_t == 0) ? 0 : cycle_t - 1;
  endfunction

  // Value loaded into the read-latency counter when a read is taken.
  function automatic int unsigned lat_load(input int unsigned lat);
    return (lat == 0) ? 0 : lat - 1;
  endfunction

  // Advance a ring pointer by one, wrapping at depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ROW_W   = 6,
  parameter int CYCLE_T = 4,
  parameter int LAT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wdata,
  output logic              free,
  output logic              done,
  output logic [WORD_W-1:0] rdata
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int BCW   = $clog2(CYCLE_T + 1);
  localparam int LCW   = $clog2(LAT + 1);

  logic [WORD_W-1:0] store [ROWS];
  logic [WORD_W-1:0] rdata_q;
  logic [BCW-1:0]    busy_cnt;
  logic [LCW-1:0]    lat_cnt;
  logic              pend;
  logic              rd_take;

  assign rd_take = acc && !acc_wr;

  // Storage array, no reset.
  always_ff @(posedge clk) begin
    if (acc && acc_wr) store[row] <= wdata;
    if (rd_take)       rdata_q    <= store[row];
  end

  // Busy counter: the bank is free when the counter is zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (acc) begin
      busy_cnt <= BCW'(busy_load(CYCLE_T));
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  // Read latency tracking: at most one read in flight, because LAT <= CYCLE_T.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      lat_cnt <= '0;
    end else if (rd_take) begin
      pend    <= 1'b1;
      lat_cnt <= LCW'(lat_load(LAT));
    end else if (pend) begin
      if (lat_cnt == '0) pend <= 1'b0;
      else               lat_cnt <= lat_cnt - 1'b1;
    end
  end

  assign free  = (busy_cnt == '0);
  assign done  = pend && (lat_cnt == '0);
  assign rdata = rdata_q;

  // R3: an access is only taken by a free bank.
  assert_accept_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> free);

  generate
    if (CYCLE_T > 1) begin : g_busy_chk
      // R3: a bank that took an access is busy on the next cycle.
      assert_busy_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !free);
    end
  endgenerate

  // R5: a taken read is pending on the next cycle.
  assert_read_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> pend);

  // R5: the done strobe lasts one cycle unless a new read was taken.
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rd_take) |=> !done);
endmodule

// File: rtl/ilv_order_fifo.sv
module ilv_order_fifo
  import ilv_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] slot [DEPTH];
  logic [PW-1:0]    wr_p, rd_p;
  logic [CW-1:0]    fill;

  always_ff @(posedge clk) begin
    if (push) slot[wr_p] <= push_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      fill <= '0;
    end else begin
      if (push) wr_p <= PW'(ring_next(32'(wr_p), DEPTH));
      if (pop)  rd_p <= PW'(ring_next(32'(rd_p), DEPTH));
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head_idx = slot[rd_p];
  assign empty    = (fill == '0);
  assign full     = (fill == CW'(DEPTH));

  // R6: the order queue never overflows or underflows.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
  import ilv_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 2,
  parameter int CYCLE_T   = 4,
  parameter int LAT       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int ROW_W = ADDR_W - BANK_BITS;

  // Named internal events
  logic [BANK_BITS-1:0] sel_bank;
  logic [ROW_W-1:0]     sel_row;
  logic                 take;
  logic                 rd_push;
  logic [NBANK-1:0]     bank_free;
  logic [NBANK-1:0]     bank_done;
  logic [NBANK-1:0]     bank_acc;
  logic [WORD_W-1:0]    bank_rdata [NBANK];
  logic [BANK_BITS-1:0] head_bank;
  logic                 q_empty, q_full;

  assign sel_bank  = req_addr[BANK_BITS-1:0];
  assign sel_row   = req_addr[ADDR_W-1:BANK_BITS];
  assign req_ready = bank_free[sel_bank] && !q_full;
  assign take      = req_valid && req_ready;
  assign rd_push   = take && (acc_kind_e'(req_write) == ACC_READ);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_acc[b] = take && (sel_bank == BANK_BITS'(b));
      ilv_bank #(
        .WORD_W (WORD_W),
        .ROW_W  (ROW_W),
        .CYCLE_T(CYCLE_T),
        .LAT    (LAT)
      ) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (bank_acc[b]),
        .acc_wr(req_write),
        .row   (sel_row),
        .wdata (req_wdata),
        .free  (bank_free[b]),
        .done  (bank_done[b]),
        .rdata (bank_rdata[b])
      );
    end
  endgenerate

  ilv_order_fifo #(
    .IDX_W(BANK_BITS),
    .DEPTH(NBANK)
  ) i_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (rd_push),
    .push_idx(sel_bank),
    .pop     (rsp_valid),
    .head_idx(head_bank),
    .empty   (q_empty),
    .full    (q_full)
  );

  assign rsp_valid = !q_empty && bank_done[head_bank];
  assign rsp_rdata = bank_rdata[head_bank];

  // R6: a bank finishes a read only when it is at the head of the order queue.
  assert_inorder_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_done) |-> (!q_empty && bank_done[head_bank]));

  // R6: at most one bank finishes a read in any cycle.
  assert_single_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_done));

  // R7: a write never enters the response order.
  assert_write_no_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write) |-> !rd_push);

  // R4: only the targeted bank is touched by a request.
  assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_acc));

  initial begin
    assert_lat_param: assert (LAT >= 1 && LAT <= CYCLE_T);
  end
endmodule

// File: tb/test_ilv_mem.sv
module test_ilv_mem;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int CYCLE_T = 4;
  localparam int LAT     = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic              req_ready, rsp_valid;
  logic [WORD_W-1:0] rsp_rdata;

  ilv_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .BANK_BITS(2),
            .CYCLE_T(CYCLE_T), .LAT(LAT)) i_ilv_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  logic [WORD_W-1:0] ref_mem [1 << ADDR_W];
  logic [WORD_W-1:0] q_data [$];
  int                q_cyc  [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare each response with the next expected item.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R7 unexpected response", 1, 0);
      end else begin
        logic [WORD_W-1:0] ed;
        int ec;
        ed = q_data.pop_front();
        ec = q_cyc.pop_front();
        chk(rsp_rdata === ed, "R1/R6 read data", rsp_rdata, ed);
        chk(cyc == ec, "R5 response cycle", cyc, ec);
      end
    end
  end

  // Driver: present one request, wait until taken, record the expectation.
  task automatic issue(input bit wr, input int addr, input logic [WORD_W-1:0] d,
                       output int acc_cyc, output int stalls);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr); req_wdata = d;
    stalls = 0;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    acc_cyc = cyc;
    if (wr) ref_mem[addr] = d;
    else begin
      q_data.push_back(ref_mem[addr]);
      q_cyc.push_back(cyc + LAT);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  bit finished = 0;

  initial begin
    int a0, a1, s0, prev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: reset state
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      req_addr = ADDR_W'(a);
      #1;
      chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R2 no response after reset", rsp_valid, 0);
    end
    // R4, R7: sequential writes stream one per cycle, no responses
    prev = -1;
    for (int a = 0; a < 16; a++) begin
      issue(1'b1, a, 32'hA500_0000 + 32'(a * 17), a0, s0);
      if (prev >= 0) chk(a0 == prev + 1, "R4 sequential write spacing", a0 - prev, 1);
      prev = a0;
    end
    // R1, R4, R5, R6: sequential reads
    prev = -1;
    for (int a = 0; a < 16; a++) begin
      issue(1'b0, a, '0, a0, s0);
      if (prev >= 0) chk(a0 == prev + 1, "R4 sequential read spacing", a0 - prev, 1);
      prev = a0;
    end
    repeat (8) @(posedge clk);
    // R3: same-bank reads stall CYCLE_T-1 cycles
    issue(1'b0, 0, '0, a0, s0);
    chk(s0 == 0, "R3 idle bank no stall", s0, 0);
    issue(1'b0, 4, '0, a1, s0);
    chk(s0 == CYCLE_T - 1, "R3 same-bank stall", s0, CYCLE_T - 1);
    chk(a1 - a0 == CYCLE_T, "R3 same-bank spacing", a1 - a0, CYCLE_T);
    issue(1'b0, 8, '0, a0, s0);
    chk(s0 == CYCLE_T - 1, "R3 second same-bank stall", s0, CYCLE_T - 1);
    // R4: a different bank is not held by a busy one
    issue(1'b0, 9, '0, a1, s0);
    chk(s0 == 0, "R4 other bank free", s0, 0);
    // R1: write then read same word, distinct rows in one bank
    issue(1'b1, 20, 32'hDEAD_0014, a0, s0);
    issue(1'b1, 84, 32'hBEEF_0054, a0, s0);
    chk(s0 == CYCLE_T - 1, "R3 write stall", s0, CYCLE_T - 1);
    issue(1'b0, 20, '0, a0, s0);
    issue(1'b0, 84, '0, a0, s0);
    // R6: scattered order across banks
    issue(1'b0, 5, '0, a0, s0);
    issue(1'b0, 2, '0, a0, s0);
    issue(1'b0, 15, '0, a0, s0);
    issue(1'b0, 1, '0, a0, s0);
    issue(1'b0, 6, '0, a0, s0);
    repeat (LAT + 4) @(posedge clk);
    chk(q_data.size() == 0, "R6 all responses returned", q_data.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule